// File: doc/BRIEF.md
# Dual Line Prefetch Fetch Unit

This block is the front end of an instruction pipeline. It keeps two 16-byte line buffers filled from memory and runs on its own, apart from the stages behind it. Memory is read a whole aligned line at a time, with a request/response handshake and only one read in flight. A buffer is refetched once the decoder has used every byte in it. While the other buffer is being read, the refill lands in the freed slot.

The decoder sees a small window of the next stream bytes and a count of how many of them are valid. Each cycle it hands back a consume count, which may differ from one instruction to the next. When the window reaches past the end of the head buffer, it continues into the other buffer in address order. A redirect throws away both buffers and any read still in flight, then restarts fetching at a new byte address.

A fetch controller built as a state machine sits beside the buffer pair. Its states are:
- OFF: reset, waiting for the first redirect.
- IDLE: armed, issues a request when a buffer is free.
- REQ: request presented.
- WAIT: response awaited.
- DROP: a stale response is awaited and will be discarded.

Its transitions are:
- OFF→IDLE on redirect.
- IDLE→REQ when a buffer is free and no redirect is present.
- REQ→WAIT on acceptance.
- REQ→IDLE on a redirect without acceptance.
- REQ→DROP on a redirect with acceptance.
- WAIT→IDLE on a response, or on a redirect together with a response.
- WAIT→DROP on a redirect without a response.
- DROP→IDLE on a response.

Top module: `pf_fetch_unit`

## Requirements
- R1: After reset, and until the first redirect, no memory request is made and the valid count is 0.
- R2: A redirect to byte address A discards both buffers. The first request that follows is for the line that contains A. The first window byte is the byte at A, and the bytes of that line below A are never shown.
- R3: Request addresses have their low 4 bits at zero. After a redirect, they follow one another line by line in steps of 16. A request that is not accepted keeps its valid and its address until it is accepted or a redirect arrives.
- R4: In a response, byte k of the line (k = 0..15) is carried on bits 8k+7..8k. Window byte i is on `win_data` bits 8i+7..8i and equals stream byte i, counted from the current read position.
- R5: A window that runs past the end of the head buffer continues with byte 0 of the other buffer, in address order, with no gap.
- R6: `win_count` equals the lesser of WIN_BYTES and the number of buffered, unconsumed bytes from the current read position. It is 0 while both buffers are empty. `consume` must not exceed `win_count`.
- R7: A buffer whose bytes have all been consumed is refilled with the next sequential line. If the decoder stops consuming, fetching continues until exactly two lines beyond the read position are held and `win_count` equals WIN_BYTES.
- R8: A response to a request accepted before a redirect, or in the same cycle as one, is discarded and never reaches the window.
- R9: A redirect takes priority over a consume and over a response in the same cycle. Both are ignored.
- R10: At most one request is outstanding. No new request is presented until the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Restart fetching at `redir_addr` |
| redir_addr | input | ADDR_W | Byte address of the new stream |
| mem_req_valid | output | 1 | Line read request |
| mem_req_addr | output | ADDR_W | Line-aligned request address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Line data returned |
| mem_resp_data | input | 8*LINE_BYTES | Line bytes, lowest address in the lowest bits |
| win_data | output | 8*WIN_BYTES | Next stream bytes, byte 0 lowest |
| win_count | output | $clog2(WIN_BYTES+1) | Number of valid window bytes |
| consume | input | $clog2(WIN_BYTES+1) | Bytes taken by the decoder this cycle |

## Verification
Two pairs of events can land in the same clock edge: a redirect together with a returning response, and the draining of the head buffer together with the refill of the other one. The bench provokes the first pair on purpose, by raising the redirect in exactly the cycle its memory model presents data. It then judges the outcome by requiring that the window after the edge shows only bytes of the new stream, with a count built up from zero. The second pair arises constantly under random consume sizes and memory latency. There the bench compares every valid window byte, and the exact count, against a stream model built from the accepted responses and the consumed bytes.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [2:0] {
        F_OFF,
        F_IDLE,
        F_REQ,
        F_WAIT,
        F_DROP
    } fetch_state_t;
endpackage

// File: rtl/pf_req_ctl.sv
module pf_req_ctl
    import pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LIDX_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir,
    input  logic [LIDX_W-1:0] redir_line,
    input  logic              req_ready,
    input  logic              resp_valid,
    input  logic              head,
    input  logic [1:0]        bvalid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              fill,
    output logic              fill_sel
);
    fetch_state_t state_q, state_d;
    logic [LIDX_W-1:0] line_q;
    logic              tgt_q;
    logic              space;

    assign space = !(bvalid[0] && bvalid[1]);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_OFF:  if (redir) state_d = F_IDLE;
            F_IDLE: if (!redir && space) state_d = F_REQ;
            F_REQ:
                if (redir)          state_d = req_ready ? F_DROP : F_IDLE;
                else if (req_ready) state_d = F_WAIT;
            F_WAIT:
                if (redir)           state_d = resp_valid ? F_IDLE : F_DROP;
                else if (resp_valid) state_d = F_IDLE;
            F_DROP: if (resp_valid) state_d = F_IDLE;
            default: state_d = F_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_OFF;
            line_q  <= '0;
            tgt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (redir)
                line_q <= redir_line;
            else if (state_q == F_REQ && req_ready)
                line_q <= line_q + 1'b1;
            if (state_q == F_IDLE && state_d == F_REQ)
                tgt_q <= bvalid[head] ? ~head : head;
        end
    end

    always_comb begin
        req_valid = (state_q == F_REQ);
        req_addr  = {line_q, {OFF_W{1'b0}}};
        fill      = (state_q == F_WAIT) && resp_valid && !redir;
        fill_sel  = tgt_q;
    end

    // R3: a pending request holds until taken or redirected
    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !redir) |=> (req_valid && $stable(req_addr)));
    // R8: nothing is written in the cycle after a redirect
    p_no_fill_after_redir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> !fill);
    // R7: a request is only presented while a buffer slot is free
    p_req_has_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (bvalid != 2'b11));
endmodule

// File: rtl/pf_buf_pair.sv
module pf_buf_pair #(
    parameter int LINE_BYTES = 16,
    parameter int WIN_BYTES  = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(WIN_BYTES + 1),
    localparam int LINE_W    = 8 * LINE_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   redir,
    input  logic [OFF_W-1:0]       redir_off,
    input  logic                   fill,
    input  logic                   fill_sel,
    input  logic [LINE_W-1:0]      fill_data,
    input  logic [CNT_W-1:0]       consume,
    output logic                   head,
    output logic [1:0]             bvalid,
    output logic [8*WIN_BYTES-1:0] win_data,
    output logic [CNT_W-1:0]       win_count
);
    localparam logic [OFF_W+1:0] LB = (OFF_W + 2)'(LINE_BYTES);
    localparam logic [OFF_W+1:0] WB = (OFF_W + 2)'(WIN_BYTES);

    logic [LINE_W-1:0] line_q [2];
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W:0]    off_sum;
    logic [OFF_W+1:0]  head_left, total;

    always_comb begin
        for (int i = 0; i < WIN_BYTES; i++) begin
            logic [OFF_W:0] idx;
            idx = {1'b0, rd_off} + (OFF_W + 1)'(i);
            win_data[i*8 +: 8] = line_q[idx[OFF_W] ^ head][idx[OFF_W-1:0]*8 +: 8];
        end
    end

    always_comb begin
        head_left = bvalid[head] ? (LB - (OFF_W + 2)'(rd_off)) : '0;
        total     = head_left + ((bvalid[head] && bvalid[~head]) ? LB : '0);
        win_count = (total > WB) ? CNT_W'(WIN_BYTES) : CNT_W'(total);
        off_sum   = {1'b0, rd_off} + (OFF_W + 1)'(consume);
    end

    always_ff @(posedge clk) begin
        if (fill) line_q[fill_sel] <= fill_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid <= 2'b00;
            head   <= 1'b0;
            rd_off <= '0;
        end else if (redir) begin
            bvalid <= 2'b00;
            rd_off <= redir_off;
        end else begin
            if (fill) bvalid[fill_sel] <= 1'b1;
            if (bvalid[head]) begin
                rd_off <= off_sum[OFF_W-1:0];
                if (off_sum[OFF_W]) begin
                    bvalid[head] <= 1'b0;
                    head         <= ~head;
                end
            end
        end
    end

    // R6: decoder never takes more than is shown
    p_consume_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume <= win_count);
    // R6: nothing shown while both buffers are empty
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid == 2'b00) |-> (win_count == '0));
    // R7: a refill only lands in an empty slot
    p_fill_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> !bvalid[fill_sel]);
    // R2: a redirect leaves both buffers empty
    p_redir_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> (bvalid == 2'b00));
endmodule

// File: rtl/pf_fetch_unit.sv
module pf_fetch_unit #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WIN_BYTES  = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(WIN_BYTES + 1),
    localparam int LINE_W    = 8 * LINE_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   redir_valid,
    input  logic [ADDR_W-1:0]      redir_addr,
    output logic                   mem_req_valid,
    output logic [ADDR_W-1:0]      mem_req_addr,
    input  logic                   mem_req_ready,
    input  logic                   mem_resp_valid,
    input  logic [LINE_W-1:0]      mem_resp_data,
    output logic [8*WIN_BYTES-1:0] win_data,
    output logic [CNT_W-1:0]       win_count,
    input  logic [CNT_W-1:0]       consume
);
    logic       head, fill, fill_sel;
    logic [1:0] bvalid;

    pf_req_ctl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir      (redir_valid),
        .redir_line (redir_addr[ADDR_W-1:OFF_W]),
        .req_ready  (mem_req_ready),
        .resp_valid (mem_resp_valid),
        .head       (head),
        .bvalid     (bvalid),
        .req_valid  (mem_req_valid),
        .req_addr   (mem_req_addr),
        .fill       (fill),
        .fill_sel   (fill_sel)
    );

    pf_buf_pair #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .redir     (redir_valid),
        .redir_off (redir_addr[OFF_W-1:0]),
        .fill      (fill),
        .fill_sel  (fill_sel),
        .fill_data (mem_resp_data),
        .consume   (consume),
        .head      (head),
        .bvalid    (bvalid),
        .win_data  (win_data),
        .win_count (win_count)
    );
endmodule

// File: tb/test_pf_fetch_unit.sv
`timescale 1ns/1ps
module test_pf_fetch_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         redir_valid;
    logic [31:0]  redir_addr;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_req_ready;
    logic         mem_resp_valid;
    logic [127:0] mem_resp_data;
    logic [31:0]  win_data;
    logic [2:0]   win_count;
    logic [2:0]   consume;

    pf_fetch_unit i_pf_fetch_unit (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .win_data(win_data), .win_count(win_count), .consume(consume)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 0;

    // model state
    bit          armed = 0, slot_busy = 0;
    int          epoch = 0, slot_epoch = 0, slot_lat = 0;
    logic [31:0] slot_addr, base, pend_addr, prev_addr;
    int          off = 0, req_cnt = 0, resp_lines = 0, consumed = 0;
    bit          prev_redir = 0, prev_req = 0, prev_rdy = 0, prev_resp = 0;
    int          prev_cons = 0;
    // controls
    bit pend_redir = 0, stall = 0, rand_redir = 0, redir_on_resp = 0, hit_resp_redir = 0;
    bit fast_mem = 0;

    function automatic logic [7:0] mb(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ (a[11:4] * 8'd29) ^ 8'h5A;
    endfunction

    function automatic logic [127:0] line_of(logic [31:0] a);
        logic [127:0] d;
        for (int k = 0; k < 16; k++) d[k*8 +: 8] = mb(a + 32'(k));
        return d;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        bit stale_now = 0, fresh = 0, do_redir;
        int avail, expc;
        @(negedge clk);
        if (prev_resp) begin
            slot_busy = 0;
            if (slot_epoch == epoch && !prev_redir) resp_lines++;
            else stale_now = 1;
        end
        if (prev_req && prev_rdy) begin
            if (!prev_redir) begin
                chk(prev_addr == base + 32'(16 * req_cnt), "R3", prev_addr, base + 32'(16 * req_cnt));
                req_cnt++;
            end
            slot_busy = 1; slot_epoch = epoch; slot_addr = prev_addr;
            slot_lat = fast_mem ? 0 : int'($urandom % 4); fresh = 1;
        end
        if (slot_busy && !fresh && slot_lat > 0) slot_lat--;
        if (!prev_redir) consumed += prev_cons;
        if (prev_redir) begin
            epoch++; base = {pend_addr[31:4], 4'h0}; off = int'(pend_addr[3:0]);
            req_cnt = 0; resp_lines = 0; consumed = 0; armed = 1;
        end
        // checks on current outputs
        if (mem_req_valid) chk(!slot_busy, "R10", mem_req_valid, 0);
        if (!armed) chk(!mem_req_valid, "R1", mem_req_valid, 0);
        if (prev_req && !prev_rdy && !prev_redir)
            chk(mem_req_valid && mem_req_addr == prev_addr, "R3", mem_req_addr, prev_addr);
        avail = resp_lines * 16 - off - consumed;
        if (avail < 0) avail = 0;
        expc = !armed ? 0 : (avail > 4 ? 4 : avail);
        chk(int'(win_count) == expc,
            !armed ? "R1" : stale_now ? "R8" : prev_redir ? "R9" : "R6", win_count, expc);
        for (int i = 0; i < 4; i++) begin
            if (i < int'(win_count)) begin
                logic [31:0] a;
                a = base + 32'(off + consumed + i);
                chk(win_data[i*8 +: 8] == mb(a),
                    (consumed == 0) ? "R2" : (a[31:4] != (base + 32'(off + consumed)) >> 4) ? "R5" : "R4",
                    win_data[i*8 +: 8], mb(a));
            end
        end
        // drive next inputs
        do_redir = pend_redir || (rand_redir && ($urandom % 40 == 0))
                   || (redir_on_resp && slot_busy && slot_lat == 0);
        if (redir_on_resp && slot_busy && slot_lat == 0) hit_resp_redir = 1;
        if (do_redir && !pend_redir) pend_addr = $urandom & 32'h0000_FFFF;
        pend_redir = 0;
        redir_valid = do_redir; redir_addr = pend_addr;
        mem_resp_valid = slot_busy && slot_lat == 0;
        mem_resp_data = mem_resp_valid ? line_of(slot_addr) : 128'h0;
        mem_req_ready = !slot_busy && (fast_mem || ($urandom % 2 == 1));
        consume = stall ? 3'd0 : 3'($urandom % (int'(win_count) + 1));
        prev_redir = do_redir; prev_req = mem_req_valid; prev_rdy = mem_req_ready;
        prev_addr = mem_req_addr; prev_resp = mem_resp_valid; prev_cons = int'(consume);
    endtask

    task automatic redirect_to(logic [31:0] a);
        pend_redir = 1; pend_addr = a;
        cyc();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; redir_valid = 0; redir_addr = 0; mem_req_ready = 0;
        mem_resp_valid = 0; mem_resp_data = 0; consume = 0; pend_addr = 0;
        repeat (3) @(negedge clk);
        chk(win_count == 3'd0 && !mem_req_valid, "R1", win_count, 0);
        rst_n = 1;
        repeat (6) cyc();
        // last byte of a line: window must cross into the next line
        redirect_to(32'h0000_100F);
        repeat (80) cyc();
        // stalled decoder: both lines held, window full
        stall = 1; fast_mem = 1;
        redirect_to(32'h0000_2007);
        repeat (40) cyc();
        checks++;
        if (win_count != 3'd4 || req_cnt - (off + consumed) / 16 != 2) begin
            failures++;
            $display("FAIL R7 actual=%0d/%0d expected=4/2", win_count, req_cnt - (off + consumed) / 16);
        end
        stall = 0; fast_mem = 0;
        repeat (30) cyc();
        // redirect in the very cycle a response is presented
        redir_on_resp = 1;
        for (int n = 0; n < 200 && !hit_resp_redir; n++) cyc();
        redir_on_resp = 0;
        chk(hit_resp_redir, "R8", hit_resp_redir, 1);
        repeat (40) cyc();
        redirect_to(32'h0000_3000);
        repeat (40) cyc();
        rand_redir = 1;
        repeat (4000) cyc();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule